// File: doc/BRIEF.md
# Subtract Instruction Execute Unit

This block is the execute slice of an 8-bit accumulator core for two subtract instructions. The first takes the working register away from an immediate byte carried in the instruction. The second takes the working register away from a byte held in the block's banked data memory. A result goes back either to the working register or to the memory location it came from. Each instruction also updates five status flags. In these flags the carry bit means "no borrow".

The surrounding core pulses `start` together with the instruction word, the current working-register value and the bank register. The block then steps through four phases: decode, operand read, compute and destination write. At the end of the write phase it pulses `done` and presents the new working register and status. While it is busy, further `start` pulses are ignored. Any other opcode takes the same four phases and changes nothing.

Top module: `sub_exec_unit`

## Requirements
- R1: After reset `wOut` is 00h, `status` is 0, `busy` and `done` are 0, and every data memory byte reads as 00h.
- R2: Instruction word 0000_1000_kkkk_kkkk (top byte 08h) computes k minus W and places it on `wOut`. The `done` pulse and the new `wOut`/`status` appear in the fourth cycle after the cycle in which `start` is sampled.
- R3: Instruction 0101_11da_ffff_ffff with d (bit 9) = 0 places memory byte minus W on `wOut` and leaves memory unchanged.
- R4: With d = 1 the difference is written back to the addressed memory byte and `wOut` keeps its previous value.
- R5: With a (bit 8) = 0, address f below 60h selects bank 0 and f of 60h or above selects the highest bank.
- R6: With a = 1 the bank is taken from `bankSel`, so the same f in different banks refers to different bytes.
- R7: `status[0]` (carry) is 1 when the minuend is greater than or equal to the subtrahend (no borrow) and 0 otherwise.
- R8: `status[1]` (digit carry) is 1 when there is no borrow out of the low nibble, that is, when the minuend's low nibble is greater than or equal to the subtrahend's.
- R9: `status[2]` (zero) is 1 when the 8-bit result is 00h, and `status[4]` (negative) equals result bit 7.
- R10: `status[3]` (overflow) is 1 when the operands have different sign bits and the result's sign differs from the minuend's sign.
- R11: Any other instruction word still produces `done` after four cycles and leaves `wOut`, `status` and memory unchanged.
- R12: `busy` is high for exactly four cycles per instruction and `done` is a single-cycle pulse. A `start` pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction (sampled when idle) |
| instr | input | 16 | Instruction word |
| wIn | input | 8 | Current working register value |
| bankSel | input | BANK_W | Bank register |
| wOut | output | 8 | Working register after the last instruction |
| status | output | 5 | {N, OV, Z, DC, C} |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle pulse when the destination write completes |

## Verification
The results of every instruction are due in the fourth clock edge after the edge that samples `start`. That edge loads `wOut`, `status`, `done` and any memory write together. Each bench operation drives its inputs on a falling edge and lets four rising edges pass. It then samples all outputs on the next falling edge, where `done` must be high. It also samples `busy` one half-cycle after the start edge. Memory contents are observed only by later register reads with W = 0, each of which takes the same four-cycle window.

// File: rtl/sub_exec_pkg.sv
package sub_exec_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_DEC, PH_RD, PH_PROC, PH_WR
  } phase_t;

  typedef struct packed {
    logic latch;
    logic decode;
    logic readMem;
    logic compute;
    logic commit;
  } strobes_t;

  localparam logic [7:0]  LIT_OPCODE = 8'h08;
  localparam logic [5:0]  REG_OPCODE = 6'b010111;
endpackage

// File: rtl/sub_exec_ctrl.sv
module sub_exec_ctrl
  import sub_exec_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  output strobes_t strobe,
  output logic     busy,
  output logic     done
);
  phase_t phase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      done  <= 1'b0;
    end else begin
      done <= (phase == PH_WR);
      unique case (phase)
        PH_IDLE: if (start) phase <= PH_DEC;
        PH_DEC:  phase <= PH_RD;
        PH_RD:   phase <= PH_PROC;
        PH_PROC: phase <= PH_WR;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.latch   = (phase == PH_IDLE) && start;
    strobe.decode  = (phase == PH_DEC);
    strobe.readMem = (phase == PH_RD);
    strobe.compute = (phase == PH_PROC);
    strobe.commit  = (phase == PH_WR);
    busy           = (phase != PH_IDLE);
  end

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R12
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && phase != PH_WR) |=> busy);

  // R2
  phase_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DEC) |=> (phase == PH_RD));
endmodule

// File: rtl/sub_exec_dp.sv
module sub_exec_dp
  import sub_exec_pkg::*;
#(
  parameter int BANK_W       = 2,
  parameter logic [7:0] ACCESS_SPLIT = 8'h60
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobe,
  input  logic [15:0]       instr,
  input  logic [7:0]        wIn,
  input  logic [BANK_W-1:0] bankSel,
  output logic [7:0]        wOut,
  output logic [4:0]        status
);
  localparam int ADDR_W    = BANK_W + 8;
  localparam int MEM_DEPTH = 1 << ADDR_W;
  localparam logic [BANK_W-1:0] TOP_BANK = '1;

  logic [15:0]       instrQ;
  logic [7:0]        wQ;
  logic [BANK_W-1:0] bankQ;
  logic              isLitQ, isRegQ, destMemQ;
  logic [ADDR_W-1:0] addrQ;
  logic [7:0]        opA, opB, resQ;
  logic [4:0]        flagsQ;
  logic [7:0]        mem [MEM_DEPTH];

  logic [BANK_W-1:0] bankPick;
  logic [8:0]        diffFull;
  logic [4:0]        diffLow;
  logic [7:0]        diff;

  always_comb begin
    if (instrQ[8])
      bankPick = bankQ;
    else if (instrQ[7:0] < ACCESS_SPLIT)
      bankPick = '0;
    else
      bankPick = TOP_BANK;
    diffFull = {1'b0, opA} + {1'b0, ~opB} + 9'd1;
    diffLow  = {1'b0, opA[3:0]} + {1'b0, ~opB[3:0]} + 5'd1;
    diff     = diffFull[7:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      instrQ   <= '0;
      wQ       <= '0;
      bankQ    <= '0;
      isLitQ   <= 1'b0;
      isRegQ   <= 1'b0;
      destMemQ <= 1'b0;
      addrQ    <= '0;
      opA      <= '0;
      opB      <= '0;
      resQ     <= '0;
      flagsQ   <= '0;
      wOut     <= '0;
      status   <= '0;
      for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= '0;
    end else begin
      if (strobe.latch) begin
        instrQ <= instr;
        wQ     <= wIn;
        bankQ  <= bankSel;
      end
      if (strobe.decode) begin
        isLitQ   <= (instrQ[15:8] == LIT_OPCODE);
        isRegQ   <= (instrQ[15:10] == REG_OPCODE);
        destMemQ <= (instrQ[15:10] == REG_OPCODE) && instrQ[9];
        addrQ    <= {bankPick, instrQ[7:0]};
      end
      if (strobe.readMem) begin
        opA <= isLitQ ? instrQ[7:0] : mem[addrQ];
        opB <= wQ;
      end
      if (strobe.compute) begin
        resQ   <= diff;
        flagsQ <= {diff[7],
                   (opA[7] != opB[7]) && (diff[7] != opA[7]),
                   (diff == 8'h00),
                   diffLow[4],
                   diffFull[8]};
      end
      if (strobe.commit && (isLitQ || isRegQ)) begin
        status <= flagsQ;
        if (destMemQ) mem[addrQ] <= resQ;
        else          wOut       <= resQ;
      end
    end
  end

  // R7
  carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.compute |=> (flagsQ[0] == (opA >= opB)));

  // R8
  digit_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.compute |=> (flagsQ[1] == (opA[3:0] >= opB[3:0])));

  // R4
  mem_dest_keeps_w_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && destMemQ) |=> $stable(wOut));

  // R11
  nop_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && !isLitQ && !isRegQ) |=> ($stable(wOut) && $stable(status)));
endmodule

// File: rtl/sub_exec_unit.sv
module sub_exec_unit
  import sub_exec_pkg::*;
#(
  parameter int BANK_W       = 2,
  parameter logic [7:0] ACCESS_SPLIT = 8'h60
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [15:0]       instr,
  input  logic [7:0]        wIn,
  input  logic [BANK_W-1:0] bankSel,
  output logic [7:0]        wOut,
  output logic [4:0]        status,
  output logic              busy,
  output logic              done
);
  strobes_t strobe;

  sub_exec_ctrl i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobe (strobe),
    .busy   (busy),
    .done   (done)
  );

  sub_exec_dp #(
    .BANK_W       (BANK_W),
    .ACCESS_SPLIT (ACCESS_SPLIT)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .instr   (instr),
    .wIn     (wIn),
    .bankSel (bankSel),
    .wOut    (wOut),
    .status  (status)
  );
endmodule

// File: tb/test_sub_exec_unit.sv
module test_sub_exec_unit;
  localparam int BANK_W = 2;
  localparam int NBYTES = 1 << (BANK_W + 8);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [15:0]       instr = '0;
  logic [7:0]        wIn = '0;
  logic [BANK_W-1:0] bankSel = '0;
  logic [7:0]        wOut;
  logic [4:0]        status;
  logic              busy, done;

  int errors = 0;
  int checks = 0;
  logic [7:0] mdlMem [NBYTES];
  logic [7:0] mdlW = 8'h00;
  logic [4:0] mdlStat = 5'h00;
  int unsigned seed = 32'h1234_5678;

  always #4 clk = ~clk;

  sub_exec_unit #(.BANK_W(BANK_W)) i_sub_exec_unit (
    .clk(clk), .rstN(rstN), .start(start), .instr(instr), .wIn(wIn),
    .bankSel(bankSel), .wOut(wOut), .status(status), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [12:0] subModel(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r;
    logic c, dc, z, ov, n;
    r  = a - b;
    c  = (a >= b);
    dc = (a[3:0] >= b[3:0]);
    z  = (r == 8'h00);
    n  = r[7];
    ov = (a[7] != b[7]) && (r[7] != a[7]);
    return {n, ov, z, dc, c, r};
  endfunction

  function automatic int addrOf(input logic [15:0] ins, input logic [BANK_W-1:0] bk);
    int bank;
    if (ins[8]) bank = bk;
    else if (ins[7:0] < 8'h60) bank = 0;
    else bank = (1 << BANK_W) - 1;
    return bank * 256 + ins[7:0];
  endfunction

  // one instruction; optionally fires a second start while busy (R12)
  task automatic doOp(input logic [15:0] ins, input logic [7:0] w,
                      input logic [BANK_W-1:0] bk, input string tag,
                      input bit poke = 1'b0);
    logic [12:0] m;
    int ad;
    @(negedge clk);
    start = 1'b1; instr = ins; wIn = w; bankSel = bk;
    @(posedge clk);
    @(negedge clk);
    start = poke; instr = 16'h0800; wIn = 8'h5A; bankSel = ~bk;
    chk(busy === 1'b1, "R12 busy after start", busy, 1);
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    if (ins[15:8] == 8'h08) begin
      m = subModel(ins[7:0], w);
      mdlW = m[7:0]; mdlStat = m[12:8];
    end else if (ins[15:10] == 6'b010111) begin
      ad = addrOf(ins, bk);
      m = subModel(mdlMem[ad], w);
      mdlStat = m[12:8];
      if (ins[9]) mdlMem[ad] = m[7:0];
      else        mdlW = m[7:0];
    end
    chk(done === 1'b1 && busy === 1'b0, {tag, " done/busy"}, {busy, done}, 1);
    chk({status, wOut} === {mdlStat, mdlW}, tag, {status, wOut}, {mdlStat, mdlW});
    @(negedge clk);
    chk(done === 1'b0, "R12 done single pulse", done, 0);
  endtask

  initial begin
    #(1_200_000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NBYTES; i++) mdlMem[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk(wOut === 8'h00 && status === 5'h00, "R1 reset wOut/status", {status, wOut}, 0);
    chk(busy === 1'b0 && done === 1'b0, "R1 reset busy/done", {busy, done}, 0);
    // R1 memory cleared: read bank2 f=33h with W=0
    doOp(16'h5D33, 8'h00, 2'd2, "R1 memory zero");
    chk(status === 5'b00111, "R1 R9 zero flags", status, 5'b00111);

    // R9 R7 examples
    doOp(16'h0802, 8'h01, 0, "R2 R7 2-1");
    chk(wOut === 8'h01 && status === 5'b00011, "R7 2-1 flags", {status, wOut}, {5'b00011, 8'h01});
    doOp(16'h0802, 8'h03, 0, "R9 2-3");
    chk(wOut === 8'hFF && status === 5'b10000, "R9 R7 2-3 flags", {status, wOut}, {5'b10000, 8'hFF});
    // R8 low-nibble borrow
    doOp(16'h0810, 8'h01, 0, "R8 10h-1");
    chk(status === 5'b00001, "R8 digit borrow", status, 5'b00001);
    // R10 overflow cases
    doOp(16'h0880, 8'h01, 0, "R10 80h-1");
    chk(status === 5'b01001, "R10 neg-pos overflow", status, 5'b01001);
    doOp(16'h087F, 8'hFF, 0, "R10 7Fh-FFh");
    chk(status === 5'b11010, "R10 pos-neg overflow", status, 5'b11010);

    // R2 R7 R8 R9 R10 literal sweep
    for (int k = 0; k < 256; k++)
      for (int w = 0; w < 256; w += 17)
        doOp({8'h08, k[7:0]}, w[7:0], 0, "R2 R7 R8 R9 R10 literal sweep");

    // R4 R6 write bank1 f=20h, then read banks 1 and 0
    doOp(16'h5F20, 8'h05, 2'd1, "R4 write bank1");
    chk(wOut === mdlW, "R4 W unchanged by memory write", wOut, mdlW);
    doOp(16'h5D20, 8'h00, 2'd1, "R3 read bank1");
    chk(wOut === 8'hFB, "R6 bank1 byte", wOut, 8'hFB);
    doOp(16'h5D20, 8'h00, 2'd0, "R6 read bank0");
    chk(wOut === 8'h00, "R6 bank0 untouched", wOut, 8'h00);
    // R5 access bank
    doOp(16'h5E70, 8'h01, 2'd1, "R5 access write high");
    doOp(16'h5D70, 8'h00, 2'd3, "R5 read top bank");
    chk(wOut === 8'hFF, "R5 high access maps top bank", wOut, 8'hFF);
    doOp(16'h5C20, 8'h00, 2'd1, "R5 access low");
    chk(wOut === 8'h00, "R5 low access maps bank0", wOut, 8'h00);

    // R3 R4 R5 R6 mixed register sweep
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] ins;
      seed = seed * 32'd1103515245 + 32'd12345;
      ins = {6'b010111, seed[20], seed[21], 8'h5C + {5'd0, seed[24:22]}};
      if (seed[27:26] == 2'b00) ins = {8'h08, seed[15:8]};
      doOp(ins, seed[7:0], seed[30:29], "R3 R4 R5 R6 mixed sweep");
    end

    // R11 other opcodes
    doOp(16'h0000, 8'h33, 0, "R11 nop 0000h");
    doOp(16'h0955, 8'h33, 1, "R11 nop 0955h");
    doOp(16'h5B20, 8'h33, 1, "R11 nop 5B20h");
    doOp(16'h6320, 8'h33, 1, "R11 nop 6320h");
    doOp(16'h5D20, 8'h00, 2'd1, "R11 memory intact");

    // R12 start while busy ignored
    doOp(16'h0840, 8'h10, 0, "R12 start while busy", 1'b1);
    @(negedge clk);
    chk(busy === 1'b0, "R12 no restart", busy, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule